// File: doc/BRIEF.md
# Real-Time Clock Snapshot Controller

This block sits between a free-running time-of-day counter chain and a byte-wide register window that a host reads and writes. It contains the sub-second prescaler that produces the one-second tick. Each tick advances the external counters. One cycle later, every counter value is copied into a set of host-visible holding registers in a single step, so the host never sees a half-updated time.

A control register at the base of the window has two halt bits. Setting either one freezes the holding registers. The host then reads a consistent snapshot while the real counters keep running. While the write-halt bit is set, the host may also overwrite the holding registers. When that bit is cleared, the block pulses a load strobe that presents the holding contents to the counter chain and restarts the prescaler from zero. The block stores each field as an opaque byte; the counter chain keeps the date and time fields in BCD.

Top module: `rtc_snap_ctrl`

## Requirements
- R1: After reset the control bits, all holding registers and `rdata_o` are zero, and `tick_o` and `load_o` are low.
- R2: `tick_o` is high for exactly one clock in every `DIV` clocks.
- R3: After each tick accepted while no halt bit is set, all seven holding registers take the live counter values in the same clock edge, two edges after the edge that raised `tick_o`. Byte i of `live_i` (bits 8i+7:8i) maps to address BASE+1+i: seconds, minutes, hours, weekday, date, month, year.
- R4: While the read-halt bit (bit 6 of the control register at BASE) is 1, the holding registers keep the values of the last completed transfer, although the counters keep advancing on every tick.
- R5: The write-halt bit (bit 7 of the control register) freezes the holding registers in the same way as the read-halt bit.
- R6: A halt bit written in the clock where `tick_o` is high, or in the clock after it, does not cancel that tick's transfer. The snapshot holds the values after that tick.
- R7: Once both halt bits are 0 again, the holding registers next update on the following tick.
- R8: Host writes to BASE+1..BASE+7 change a holding register only while the write-halt bit is 1. Otherwise they are ignored.
- R9: A control write that changes the write-halt bit from 1 to 0 raises `load_o` for one clock, with `load_data_o` equal to the holding registers. It restarts the prescaler, so the next tick comes `DIV` clocks after `load_o` rises.
- R10: The control register reads back only bits 7 and 6. Bits 5:0 read 0 whatever was written to them. Addresses outside BASE..BASE+7 read as 0.
- R11: `rdata_o` takes the addressed value at the edge where `cs_i` and `rd_i` are both high, and holds it while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_i | input | 1 | Window select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | AW | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| live_i | input | 8*NF | Live counter values, byte 0 = seconds |
| tick_o | output | 1 | One-second advance pulse to the counters |
| load_o | output | 1 | Counter load strobe |
| load_data_o | output | 8*NF | Values to load into the counters |

## Verification
A host read is due one edge after its strobe, so the bench samples `rdata_o` at the following falling edge. A tick seen high at a falling edge is applied to the counter model at the next rising edge. The holding registers copy at the rising edge after that, so every snapshot read starts two falling edges after the tick is seen. The halt-race case drives the control write in the tick clock itself, and again one clock later. `load_o` is checked at the first falling edge after the clearing write, and the spacing to the next tick is counted in whole clocks against `DIV`.

// File: rtl/rtc_snap_pkg.sv
// Shared constants for the snapshot controller.
// Assumes byte-wide fields and a control register at the window base.
package rtc_snap_pkg;
    localparam int BYTE_W      = 8;
    localparam int CTRL_WR_BIT = 7;   // write-halt: freeze, then load counters on clear
    localparam int CTRL_RD_BIT = 6;   // read-halt: freeze only
endpackage

// File: rtl/rtc_prescaler.sv
// Sub-second divider: raises tick for one clock every DIV clocks.
// Assumes DIV >= 2; clr restarts the count from zero and suppresses the tick.
module rtc_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // count clocks and emit one pulse per period
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/rtc_xfer_ctl.sv
// Transfer scheduler: turns an accepted tick into a one-clock copy request.
// Assumes halt comes from the registered control bits, so a halt written in
// the tick clock is not yet visible and the transfer still goes ahead.
module rtc_xfer_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic halt,
    output logic pend
);
    // accept a tick only while not halted; once set, the copy always completes
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= tick & ~halt;
    end
endmodule

// File: rtl/rtc_hold_regs.sv
// Host window: control bits, holding registers and registered read port.
// Assumes a pending transfer takes priority over a host write to a field.
module rtc_hold_regs
    import rtc_snap_pkg::*;
#(
    parameter int              AW   = 13,
    parameter int              NF   = 7,
    parameter logic [AW-1:0]   BASE = 13'h1FF8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_wr,
    input  logic                   host_rd,
    input  logic [AW-1:0]          addr_i,
    input  logic [BYTE_W-1:0]      wdata_i,
    input  logic [NF*BYTE_W-1:0]   live_i,
    input  logic                   pend,
    output logic [NF*BYTE_W-1:0]   hold_o,
    output logic                   halt_o,
    output logic                   wr_fall_o,
    output logic                   load_o,
    output logic [BYTE_W-1:0]      rdata_o
);
    logic rd_bit_q, wr_bit_q;
    logic ctrl_sel;
    logic [BYTE_W-1:0] rmux;

    assign ctrl_sel  = (addr_i == BASE);
    assign halt_o    = rd_bit_q | wr_bit_q;
    assign wr_fall_o = host_wr & ctrl_sel & wr_bit_q & ~wdata_i[CTRL_WR_BIT];

    // control register: only the two halt bits are stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_bit_q <= 1'b0;
            wr_bit_q <= 1'b0;
        end else if (host_wr && ctrl_sel) begin
            rd_bit_q <= wdata_i[CTRL_RD_BIT];
            wr_bit_q <= wdata_i[CTRL_WR_BIT];
        end
    end

    // load strobe: one clock after the write-halt bit is cleared
    always_ff @(posedge clk) begin
        if (!rst_n) load_o <= 1'b0;
        else        load_o <= wr_fall_o;
    end

    for (genvar i = 0; i < NF; i++) begin : g_field
        localparam logic [AW-1:0] FADDR = AW'(int'(BASE) + 1 + i);
        // one holding byte: copy from counters, or host write under write-halt
        always_ff @(posedge clk) begin
            if (!rst_n)
                hold_o[i*BYTE_W +: BYTE_W] <= '0;
            else if (pend)
                hold_o[i*BYTE_W +: BYTE_W] <= live_i[i*BYTE_W +: BYTE_W];
            else if (host_wr && wr_bit_q && addr_i == FADDR)
                hold_o[i*BYTE_W +: BYTE_W] <= wdata_i;
        end
    end

    // read multiplexer over the window; unmapped addresses give zero
    always_comb begin
        rmux = '0;
        if (ctrl_sel) begin
            rmux[CTRL_WR_BIT] = wr_bit_q;
            rmux[CTRL_RD_BIT] = rd_bit_q;
        end
        for (int i = 0; i < NF; i++)
            if (addr_i == AW'(int'(BASE) + 1 + i))
                rmux = hold_o[i*BYTE_W +: BYTE_W];
    end

    // registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_o <= '0;
        else if (host_rd) rdata_o <= rmux;
    end
endmodule

// File: rtl/rtc_snap_ctrl.sv
// Top: prescaler, transfer scheduler and host window for a time-of-day
// counter chain kept outside this block. Assumes the counters advance on
// tick_o and load load_data_o when load_o is high.
module rtc_snap_ctrl
    import rtc_snap_pkg::*;
#(
    parameter int            AW   = 13,
    parameter int            NF   = 7,
    parameter logic [AW-1:0] BASE = 13'h1FF8,
    parameter int            DIV  = 32768
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_i,
    input  logic                  wr_i,
    input  logic                  rd_i,
    input  logic [AW-1:0]         addr_i,
    input  logic [7:0]            wdata_i,
    output logic [7:0]            rdata_o,
    input  logic [NF*8-1:0]       live_i,
    output logic                  tick_o,
    output logic                  load_o,
    output logic [NF*8-1:0]       load_data_o
);
    logic host_wr, host_rd, halt, wr_fall, xfer_pend;
    logic [NF*BYTE_W-1:0] hold;

    assign host_wr     = cs_i & wr_i;
    assign host_rd     = cs_i & rd_i;
    assign load_data_o = hold;

    rtc_prescaler #(.DIV(DIV)) u_presc (
        .clk(clk), .rst_n(rst_n), .clr(wr_fall), .tick(tick_o)
    );

    rtc_xfer_ctl u_xfer (
        .clk(clk), .rst_n(rst_n), .tick(tick_o), .halt(halt), .pend(xfer_pend)
    );

    rtc_hold_regs #(.AW(AW), .NF(NF), .BASE(BASE)) u_regs (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .addr_i(addr_i), .wdata_i(wdata_i), .live_i(live_i), .pend(xfer_pend),
        .hold_o(hold), .halt_o(halt), .wr_fall_o(wr_fall), .load_o(load_o),
        .rdata_o(rdata_o)
    );
endmodule

// File: rtl/rtc_snap_chk.sv
// Checker for rtc_snap_ctrl: timing of tick and load pulses, atomic copy,
// freeze under halt and read-data hold. Attached by bind below.
module rtc_snap_chk #(
    parameter int W = 56
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         load,
    input logic         pend,
    input logic         halt,
    input logic         host_wr,
    input logic         host_rd,
    input logic [W-1:0] hold,
    input logic [W-1:0] live,
    input logic [7:0]   rdata
);
    p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    p_copy_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> (hold == $past(live)));

    p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !pend && !host_wr) |=> $stable(hold));

    p_load_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);

    p_load_restarts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !tick);

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(rdata));
endmodule

bind rtc_snap_ctrl rtc_snap_chk #(.W(NF*8)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick_o), .load(load_o), .pend(xfer_pend),
    .halt(halt), .host_wr(host_wr), .host_rd(host_rd), .hold(hold),
    .live(live_i), .rdata(rdata_o)
);

// File: tb/test_rtc_snap_ctrl.sv
module test_rtc_snap_ctrl;
    localparam int AW = 13;
    localparam int NF = 7;
    localparam logic [AW-1:0] BASE = 13'h1FF8;
    localparam int DIV = 32;

    logic clk = 0, rst_n = 0;
    logic cs = 0, wr = 0, rd = 0;
    logic [AW-1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [NF*8-1:0] live, load_data;
    logic tick, load;
    int n;               // counter model: seconds since midnight
    int total = 0, bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    rtc_snap_ctrl #(.AW(AW), .NF(NF), .BASE(BASE), .DIV(DIV)) i_rtc_snap_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .wr_i(wr), .rd_i(rd),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .live_i(live),
        .tick_o(tick), .load_o(load), .load_data_o(load_data)
    );

    function automatic logic [7:0] bcd(int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction
    function automatic int unbcd(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction
    function automatic logic [7:0] exp_byte(int i, int s);
        case (i)
            0: return bcd(s % 60);
            1: return bcd((s / 60) % 60);
            2: return bcd(s / 3600);
            3: return 8'h03;
            4: return 8'h17;
            5: return 8'h06;
            default: return 8'h25;
        endcase
    endfunction

    always_comb
        for (int i = 0; i < NF; i++) live[i*8 +: 8] = exp_byte(i, n);

    // external counter chain model
    always @(posedge clk) begin
        if (!rst_n)    n <= 86380;
        else if (load) n <= unbcd(load_data[23:16]) * 3600 + unbcd(load_data[15:8]) * 60
                            + unbcd(load_data[7:0]);
        else if (tick) n <= (n + 1) % 86400;
    end

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr_reg(logic [AW-1:0] a, logic [7:0] d);
        cs = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk);
        cs = 0; wr = 0;
    endtask
    task automatic rd_reg(logic [AW-1:0] a, output logic [7:0] v);
        cs = 1; rd = 1; addr = a;
        @(negedge clk);
        cs = 0; rd = 0;
        v = rdata;
    endtask
    task automatic wait_tick();
        do @(negedge clk); while (!tick);
    endtask
    task automatic idle(int k);
        repeat (k) @(negedge clk);
    endtask
    task automatic chk_fields(string tag, int s);
        logic [7:0] v;
        for (int i = 0; i < NF; i++) begin
            rd_reg(BASE + AW'(1 + i), v);
            chk(tag, v, exp_byte(i, s));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int c, snap;
        idle(3);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tick", tick, 0);
        chk("R1 load", load, 0);
        chk("R1 rdata", rdata, 0);
        rd_reg(BASE, v); chk("R1 ctrl", v, 0);
        for (int i = 0; i < NF; i++) begin
            rd_reg(BASE + AW'(1 + i), v); chk("R1 hold", v, 0);
        end
        // R2 tick spacing
        wait_tick();
        c = 0;
        do begin @(negedge clk); c++; end while (!tick);
        chk("R2 period", c, DIV);
        // R3 sweep across many ticks, including midnight rollover
        for (int t = 0; t < 30; t++) begin
            wait_tick(); idle(2);
            chk_fields("R3 snapshot", n);
        end
        // R4 + R10: read-halt, low control bits dropped
        wait_tick(); idle(2);
        snap = n;
        wr_reg(BASE, 8'h7F);
        rd_reg(BASE, v); chk("R10 ctrl readback", v, 8'h40);
        for (int k = 0; k < 3; k++) wait_tick();
        idle(2);
        chk("R4 counters run", n, (snap + 3) % 86400);
        chk_fields("R4 frozen", snap);
        // R8: field write ignored without write-halt
        wr_reg(BASE + 1, 8'h59);
        rd_reg(BASE + 1, v); chk("R8 ignored", v, exp_byte(0, snap));
        // R7: resume on next tick
        wr_reg(BASE, 8'h00);
        wait_tick(); idle(2);
        chk_fields("R7 resume", n);
        // R6: halt written in the tick clock
        wait_tick();
        wr_reg(BASE, 8'h40);
        snap = n;
        wait_tick(); wait_tick(); idle(2);
        chk_fields("R6 tick-clock halt", snap);
        wr_reg(BASE, 8'h00);
        // R6: halt written in the clock after the tick
        wait_tick(); idle(1);
        snap = n;
        wr_reg(BASE, 8'h80);
        wait_tick(); wait_tick(); idle(2);
        chk_fields("R6 pending halt", snap);
        // R5 + R8: write-halt accepts host writes and stays frozen
        wr_reg(BASE + 1, 8'h30);
        wr_reg(BASE + 2, 8'h45);
        wr_reg(BASE + 3, 8'h12);
        rd_reg(BASE, v); chk("R5 ctrl readback", v, 8'h80);
        chk_fields("R8 host write", 12 * 3600 + 45 * 60 + 30);
        wait_tick(); idle(2);
        chk_fields("R5 frozen", 12 * 3600 + 45 * 60 + 30);
        // R9: clearing write-halt loads the counters and restarts the prescaler
        wr_reg(BASE, 8'h00);
        chk("R9 load pulse", load, 1);
        chk("R9 load data", int'(load_data[23:0]), 24'h124530);
        chk("R9 load upper", int'(load_data[55:24]), 32'h25061703);
        c = 0;
        do begin @(negedge clk); c++; end while (!tick);
        chk("R9 restart", c, DIV);
        idle(2);
        chk_fields("R9 loaded time", 12 * 3600 + 45 * 60 + 31);
        // R10 unmapped address, R11 read hold
        rd_reg(13'h0000, v); chk("R10 unmapped", v, 0);
        rd_reg(BASE + 2, v);
        idle(3);
        chk("R11 rdata held", rdata, v);
        chk("R11 rdata value", v, 8'h45);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule